// File: doc/BRIEF.md
# Clock domain sleep/wake controller

This block decides when the functional clock of one power-managed clock domain may stop. Software selects a transition mode through a 2-bit field. Hardware inputs report whether every module in the domain is idle and whether any module wants a wakeup. A static dependency mask names the other domains whose activity keeps this domain running. The block drives a clock enable, a two-bit domain state and a transition interrupt status bit.

The controller has three states. In ACTIVE the clock runs. IDLE_PENDING is a programmable dwell during which the idle condition must hold without a break. In SLEEP the clock enable is low. Mode 0 keeps the clock running and behaves like mode 2. Mode 2 forces a wakeup. Mode 1 and mode 3 both let the domain sleep once it is idle. They differ in one respect only: entering SLEEP under mode 1 raises the interrupt status, and mode 3 does not.

Software reaches the block through a small word-wide register port. The port has four addresses: control, dependency-set, dependency-clear and status. Reads return data combinationally. Writes take effect at the clock edge.

Top module: `clkdm_ctrl`

## Requirements
- R1: After reset the state is ACTIVE (0), `clk_en` is 1, `irq_trans` is 0, the mode is 0, the dwell is 0 and the dependency mask is all zero.
- R2: In mode 0 or mode 2 the state is ACTIVE in the cycle after that mode is in force, whatever the idle, wakeup and source inputs are.
- R3: In mode 1 or mode 3, with the idle condition true, ACTIVE moves to IDLE_PENDING at the next edge. IDLE_PENDING lasts dwell+1 cycles, then the state becomes SLEEP and `clk_en` is 0.
- R4: The idle condition is `all_idle` high, `wake_req` low and no masked source active. If it is false during IDLE_PENDING or SLEEP, the state returns to ACTIVE at the next edge and `clk_en` is 1 from that cycle on.
- R5: An active `src_active` bit whose dependency-mask bit is set prevents SLEEP. An active source whose mask bit is clear has no effect.
- R6: At address 1 (set), each 1 bit in `reg_wdata[NSRC-1:0]` sets the matching mask bit. At address 2 (clear), each 1 bit clears the matching mask bit, so one write can clear several bits. Reads at address 1 or 2 return the mask.
- R7: Each entry into SLEEP while the mode is 1 sets `irq_trans`. An entry under mode 3 leaves it unchanged.
- R8: Writing 1 to bit 0 at address 3 clears `irq_trans`. If a mode-1 sleep entry happens in the same cycle, the bit stays set.
- R9: `dom_state` and status read bits [5:4] report ACTIVE as 0, IDLE_PENDING as 1 and SLEEP as 2. Status bit 0 reads `irq_trans`.
- R10: Address 0 holds the mode in bits [1:0] and the dwell count in bits [8+DWELL_W-1:8]. A read at address 0 returns both fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 dependency set, 2 dependency clear, 3 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| all_idle | input | 1 | Every module in the domain is idle |
| wake_req | input | 1 | A module in the domain requests wakeup |
| src_active | input | NSRC | Activity of each source domain |
| clk_en | output | 1 | Functional clock enable |
| dom_state | output | 2 | Current state: 0 ACTIVE, 1 IDLE_PENDING, 2 SLEEP |
| irq_trans | output | 1 | Transition interrupt status, cleared by writing 1 |

## Verification
`dom_state` exposes the controller state on every cycle. A wrong state, or a wrong dwell count, therefore shows up at the first edge where it diverges: SLEEP is entered one cycle early or late, or a wakeup fails to raise `clk_en` in the following cycle. A corrupted mode or dependency bit can stay hidden until idle is asserted. The register readback exposes it at once. An interrupt set by mode 3, or lost to a clear in the same cycle, appears on `irq_trans` one cycle after the sleep entry.

// File: rtl/clkdm_pkg.sv
// Shared types for the clock domain controller.
// Assumes a 2-bit mode field and a 2-bit state code.
package clkdm_pkg;
    typedef enum logic [1:0] {
        MD_NEVER  = 2'd0,
        MD_FSLEEP = 2'd1,
        MD_FWAKE  = 2'd2,
        MD_AUTO   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_PEND   = 2'd1,
        ST_SLEEP  = 2'd2
    } state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DSET = 2'd1;
    localparam logic [1:0] A_DCLR = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/clkdm_regs.sv
// Register file: mode, dwell and dependency mask; read mux; status clear strobe.
// Assumes DATA_W >= 8 + DWELL_W and DATA_W >= NSRC and DATA_W >= 6.
module clkdm_regs
    import clkdm_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int DWELL_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               irq,
    input  state_e             state,
    output mode_e              mode,
    output logic [DWELL_W-1:0] dwell,
    output logic [NSRC-1:0]    dep_mask,
    output logic               irq_clr,
    output logic [DATA_W-1:0]  rdata
);
    localparam int DWELL_LSB = 8;

    // Control register: mode and dwell count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MD_NEVER;
            dwell <= '0;
        end else if (wr && addr == A_CTRL) begin
            mode  <= mode_e'(wdata[1:0]);
            dwell <= wdata[DWELL_LSB +: DWELL_W];
        end
    end

    // One flop per dependency bit, with separate set and clear addresses.
    for (genvar g = 0; g < NSRC; g++) begin : g_dep
        always_ff @(posedge clk) begin
            if (!rst_n)
                dep_mask[g] <= 1'b0;
            else if (wr && addr == A_DSET && wdata[g])
                dep_mask[g] <= 1'b1;
            else if (wr && addr == A_DCLR && wdata[g])
                dep_mask[g] <= 1'b0;
        end
    end

    // Clear strobe for the interrupt status.
    assign irq_clr = wr && addr == A_STAT && wdata[0];

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[1:0]                     = mode;
                rdata[DWELL_LSB +: DWELL_W]    = dwell;
            end
            A_DSET, A_DCLR: rdata[NSRC-1:0] = dep_mask;
            default: begin
                rdata[0]   = irq;
                rdata[5:4] = state;
            end
        endcase
    end
endmodule

// File: rtl/clkdm_fsm.sv
// Sleep/wake state machine with dwell counter.
// Leaves SLEEP or IDLE_PENDING as soon as the idle condition fails or the mode forbids sleep.
module clkdm_fsm
    import clkdm_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mode_e              mode,
    input  logic [DWELL_W-1:0] dwell,
    input  logic               all_idle,
    input  logic               wake_req,
    input  logic [NSRC-1:0]    src_active,
    input  logic [NSRC-1:0]    dep_mask,
    output state_e             state,
    output logic               sleep_evt
);
    state_e             state_n;
    logic [DWELL_W-1:0] cnt_q, cnt_n;
    logic               idle_ok, may_sleep;

    // Idle condition including the static dependencies.
    assign idle_ok   = all_idle && !wake_req && ((src_active & dep_mask) == '0);
    assign may_sleep = (mode == MD_FSLEEP) || (mode == MD_AUTO);

    // Next-state and dwell count logic.
    always_comb begin
        state_n   = state;
        cnt_n     = cnt_q;
        sleep_evt = 1'b0;
        if (!may_sleep || !idle_ok) begin
            state_n = ST_ACTIVE;
        end else begin
            case (state)
                ST_ACTIVE: begin
                    state_n = ST_PEND;
                    cnt_n   = dwell;
                end
                ST_PEND: begin
                    if (cnt_q == '0) begin
                        state_n   = ST_SLEEP;
                        sleep_evt = (mode == MD_FSLEEP);
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
                default: state_n = ST_SLEEP;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
            cnt_q <= '0;
        end else begin
            state <= state_n;
            cnt_q <= cnt_n;
        end
    end
endmodule

// File: rtl/clkdm_irq.sv
// Transition interrupt status bit; a set in the same cycle as a clear wins.
module clkdm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    // Sticky status with write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (set)
            irq <= 1'b1;
        else if (clr)
            irq <= 1'b0;
    end
endmodule

// File: rtl/clkdm_ctrl.sv
// Top of the clock domain sleep/wake controller.
// Joins the register file, the state machine and the interrupt status.
// Assumes all inputs are synchronous to clk.
module clkdm_ctrl
    import clkdm_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int DWELL_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              all_idle,
    input  logic              wake_req,
    input  logic [NSRC-1:0]   src_active,
    output logic              clk_en,
    output logic [1:0]        dom_state,
    output logic              irq_trans
);
    mode_e              mode_q;
    logic [DWELL_W-1:0] dwell_q;
    logic [NSRC-1:0]    dep_mask;
    logic               irq_clr, sleep_evt;
    state_e             state_q;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata;

    clkdm_regs #(.NSRC(NSRC), .DWELL_W(DWELL_W), .DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .irq(irq_trans), .state(state_q), .mode(mode_q), .dwell(dwell_q),
        .dep_mask(dep_mask), .irq_clr(irq_clr), .rdata(reg_rdata)
    );

    clkdm_fsm #(.NSRC(NSRC), .DWELL_W(DWELL_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .dwell(dwell_q),
        .all_idle(all_idle), .wake_req(wake_req), .src_active(src_active),
        .dep_mask(dep_mask), .state(state_q), .sleep_evt(sleep_evt)
    );

    clkdm_irq i_irq (
        .clk(clk), .rst_n(rst_n), .set(sleep_evt), .clr(irq_clr), .irq(irq_trans)
    );

    // Clock runs in every state except SLEEP.
    assign clk_en    = (state_q != ST_SLEEP);
    assign dom_state = state_q;
endmodule

// File: rtl/clkdm_ctrl_chk.sv
// Property checker for clkdm_ctrl, attached by bind.
module clkdm_ctrl_chk
    import clkdm_pkg::*;
#(
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode,
    input logic [1:0]      state,
    input logic            clk_en,
    input logic            irq,
    input logic            wake_req,
    input logic [NSRC-1:0] src_active,
    input logic [NSRC-1:0] dep_mask
);
    // R2: never-sleep and forced-wake modes hold ACTIVE.
    p_forced_awake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_NEVER || mode == MD_FWAKE) |=> state == ST_ACTIVE);

    // R3: SLEEP is only reached through IDLE_PENDING.
    p_sleep_via_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SLEEP) |-> $past(state) == ST_PEND);

    // R4: a wakeup in SLEEP restores the clock next cycle.
    p_wake_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_req) |=> clk_en);

    // R5: an active masked source keeps the domain out of SLEEP.
    p_dep_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_active & dep_mask) != '0) |=> state != ST_SLEEP);

    // R7: the interrupt only rises on a mode-1 sleep entry.
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(mode) == MD_FSLEEP && $past(state) == ST_PEND));

    // R9: state code 3 never appears.
    p_state_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);
endmodule

bind clkdm_ctrl clkdm_ctrl_chk #(.NSRC(NSRC)) i_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .state(state_q), .clk_en(clk_en),
    .irq(irq_trans), .wake_req(wake_req), .src_active(src_active), .dep_mask(dep_mask)
);

// File: tb/test_clkdm_ctrl.sv
`timescale 1ns/1ps
module test_clkdm_ctrl;
    localparam int NSRC = 8;
    localparam int DW   = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              all_idle = 1'b0;
    logic              wake_req = 1'b0;
    logic [NSRC-1:0]   src_active = '0;
    logic              clk_en;
    logic [1:0]        dom_state;
    logic              irq_trans;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 0;

    // Reference model state
    int            m_mode, m_dwell, m_state, m_cnt;
    logic [NSRC-1:0] m_mask;
    bit            m_irq;

    always #4 clk = ~clk;

    clkdm_ctrl #(.NSRC(NSRC), .DWELL_W(DW), .DATA_W(DATA_W)) i_clkdm_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .all_idle(all_idle),
        .wake_req(wake_req), .src_active(src_active), .clk_en(clk_en),
        .dom_state(dom_state), .irq_trans(irq_trans)
    );

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        int ns, nc;
        bit ok, allow, evt;
        if (!rst_n) begin
            m_mode <= 0; m_dwell <= 0; m_state <= 0; m_cnt <= 0;
            m_mask <= '0; m_irq <= 0;
        end else begin
            ns = m_state; nc = m_cnt; evt = 0;
            ok = all_idle && !wake_req && ((src_active & m_mask) == 0);
            allow = (m_mode == 1) || (m_mode == 3);
            if (!allow || !ok) ns = 0;
            else if (m_state == 0) begin ns = 1; nc = m_dwell; end
            else if (m_state == 1) begin
                if (m_cnt == 0) begin ns = 2; evt = (m_mode == 1); end
                else nc = m_cnt - 1;
            end
            m_state <= ns;
            m_cnt   <= nc;
            if (evt) m_irq <= 1;
            else if (reg_wr && reg_addr == 3 && reg_wdata[0]) m_irq <= 0;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: begin m_mode <= int'(reg_wdata[1:0]); m_dwell <= int'(reg_wdata[15:8]); end
                    2'd1: m_mask <= m_mask | reg_wdata[NSRC-1:0];
                    2'd2: m_mask <= m_mask & ~reg_wdata[NSRC-1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [DATA_W-1:0] exp_rdata(input logic [1:0] a);
        logic [DATA_W-1:0] r;
        r = '0;
        case (a)
            2'd0: begin r[1:0] = m_mode[1:0]; r[15:8] = m_dwell[7:0]; end
            2'd1, 2'd2: r[NSRC-1:0] = m_mask;
            default: begin r[0] = m_irq; r[5:4] = m_state[1:0]; end
        endcase
        return r;
    endfunction

    task automatic cmp(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            cmp("R3", "clk_en", clk_en, (m_state != 2));
            cmp("R9", "dom_state", dom_state, m_state);
            cmp("R7", "irq_trans", irq_trans, m_irq);
            cmp("R6", "reg_rdata", reg_rdata, exp_rdata(reg_addr));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        cmp_on = 1;
        cmp("R1", "reset clk_en", clk_en, 1);
        cmp("R1", "reset state", dom_state, 0);
        cmp("R1", "reset irq", irq_trans, 0);
        cmp("R1", "reset ctrl", reg_rdata, 0);

        // R2: mode 0 never sleeps even when idle
        all_idle = 1'b1;
        step(10);
        cmp("R2", "mode0 idle state", dom_state, 0);

        // R10, R3: mode 3 dwell 3
        wr(2'd0, 32'h0303);
        cmp("R10", "ctrl readback", reg_rdata, 32'h0303);
        step(4);
        cmp("R3", "pending after dwell-1", dom_state, 1);
        step(1);
        cmp("R3", "sleep state", dom_state, 2);
        cmp("R3", "sleep clk_en", clk_en, 0);
        cmp("R7", "mode3 no irq", irq_trans, 0);

        // R4: wakeup request
        wake_req = 1'b1;
        step(1);
        cmp("R4", "wake state", dom_state, 0);
        cmp("R4", "wake clk_en", clk_en, 1);
        wake_req = 1'b0;

        // R7, R9: mode 1 dwell 0
        wr(2'd0, 32'h0001);
        step(5);
        cmp("R7", "mode1 irq", irq_trans, 1);
        reg_addr = 2'd3;
        #1;
        cmp("R9", "status read", reg_rdata, 32'h21);

        // R8: clear, then clear coinciding with set
        wr(2'd3, 32'h1);
        cmp("R8", "w1c", irq_trans, 0);
        all_idle = 1'b0;
        step(1);
        all_idle = 1'b1;
        step(1);
        cmp("R8", "pending before coincident clear", dom_state, 1);
        wr(2'd3, 32'h1);
        cmp("R8", "set wins over clear", irq_trans, 1);

        // R5, R6: dependencies under mode 3 dwell 0
        wr(2'd0, 32'h0003);
        wr(2'd3, 32'h1);
        wr(2'd1, 32'h05);
        cmp("R6", "mask set read", reg_rdata, 32'h05);
        src_active = 8'h02;
        all_idle = 1'b0;
        step(1);
        all_idle = 1'b1;
        step(3);
        cmp("R5", "unmasked source ignored", dom_state, 2);
        src_active = 8'h04;
        step(1);
        cmp("R5", "masked source wakes", dom_state, 0);
        step(5);
        cmp("R5", "masked source holds", dom_state, 0);
        wr(2'd2, 32'h05);
        cmp("R6", "multi clear read", reg_rdata, 32'h0);
        step(3);
        cmp("R5", "cleared mask allows sleep", dom_state, 2);

        // R2: forced wakeup from SLEEP
        wr(2'd0, 32'h0002);
        step(1);
        cmp("R2", "mode2 wakes", dom_state, 0);
        cmp("R2", "mode2 clk_en", clk_en, 1);

        // R4: idle drop in IDLE_PENDING, then mode 0 from IDLE_PENDING
        src_active = '0;
        wr(2'd0, 32'h0503);
        step(3);
        cmp("R4", "pending", dom_state, 1);
        all_idle = 1'b0;
        step(1);
        cmp("R4", "idle drop returns active", dom_state, 0);
        all_idle = 1'b1;
        step(2);
        cmp("R3", "pending again", dom_state, 1);
        wr(2'd0, 32'h0500);
        step(1);
        cmp("R2", "mode0 leaves pending", dom_state, 0);
        step(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule